// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small shared word memory used by several cores and gives them a lock-free read-modify-write primitive. Each core may issue a plain load, a plain store, a linked load or a conditional store. A linked load reads a word and arms a per-core reservation on that address. A later conditional store from the same core writes only if no write has touched that address in the meantime. It reports 1 on success and 0 on failure.

All cores share one memory port. A round-robin arbiter grants at most one request per cycle. The granted request reaches memory and the reservation table at the next clock edge. The requester sees a response pulse one cycle after its grant. Every write that lands snoops the reservation table and disarms all reservations on the written address. The outcome of a conditional store therefore reflects every write since that core's linked load, not only the request in flight.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every memory word reads 0, no core holds a reservation, and grant_o and rsp_valid_o are all zero.
- R2: A plain load (op code 2'b00) returns the addressed word on rsp_data_o in the cycle after its grant.
- R3: A plain store (op code 2'b01) writes its data at the grant edge and returns 0 on rsp_data_o.
- R4: A linked load (op code 2'b10) returns the addressed word and arms the requesting core's reservation on that address.
- R5: A conditional store (op code 2'b11) from a core whose reservation is armed on the same address writes its data and returns 1.
- R6: A conditional store with no armed reservation, or with a reservation on a different address, returns 0 and leaves memory unchanged.
- R7: Any write that lands, whether a plain store or a successful conditional store from any core, disarms every reservation on the written address. A write to a different address leaves reservations intact.
- R8: A conditional store always disarms the issuing core's reservation, so a second conditional store without a new linked load fails.
- R9: A new linked load replaces the core's earlier reservation; only the latest address can succeed.
- R10: At most one core is granted per cycle, only a core with req_valid_i set is granted, and rsp_valid_o one cycle later equals that grant.
- R11: Arbitration is round-robin. The grant goes to the first requesting core after the last granted core, in cyclic index order. Core 0 is first after reset.
- R12: When several cores issue conditional stores to one reserved address together, exactly one of them succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_CORES | Per-core request; held until granted |
| req_op_i | input | 2*N_CORES | Per-core op code: 00 load, 01 store, 10 linked load, 11 conditional store |
| req_addr_i | input | N_CORES*ADDR_W | Per-core word address |
| req_wdata_i | input | N_CORES*DATA_W | Per-core write data |
| grant_o | output | N_CORES | One-hot grant, combinational from requests |
| rsp_valid_o | output | N_CORES | Response pulse to the core granted in the previous cycle |
| rsp_data_o | output | DATA_W | Shared response data: read word, 0 for a store, 0/1 for a conditional store |

## Verification
The bound checker watches the arbitration and response framing on every cycle. It checks that grants are one-hot and go only to requesters, and that the response pulse mirrors the previous grant. It also checks that stores answer 0 and conditional stores answer only 0 or 1. Reservation lifetime depends on the history of writes since a core's linked load, so only bench scenarios can show it. These scenarios cover interference from every other core, replacement by a newer linked load, self-clearing, a write to a different address, and four simultaneous conditional stores racing for one address.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } mem_op_e;
endpackage

// File: rtl/llsc_rr_arbiter.sv
module llsc_rr_arbiter #(
  parameter int unsigned N = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [IDX_W-1:0] last_q;

  // search starts one past the last winner
  always_comb begin
    int unsigned cand;
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int unsigned k = 1; k <= N; k++) begin
      cand = (int'(last_q) + k) % N;
      if (!any_o && req_i[cand]) begin
        any_o       = 1'b1;
        gnt_o[cand] = 1'b1;
        idx_o       = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IDX_W'(N - 1);
    else if (any_o) last_q <= idx_o;
  end
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_any_i,
  input  logic [IDX_W-1:0]  gnt_idx_i,
  input  mem_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic              hit_o
);
  logic [N-1:0]      vld_q;
  logic [ADDR_W-1:0] addr_q [N];

  for (genvar g = 0; g < int'(N); g++) begin : g_entry
    logic own, set, clr;
    assign own = gnt_any_i && (gnt_idx_i == IDX_W'(g));
    assign set = own && (op_i == OP_LINK);
    // snoop: any landed write to this address, or own conditional store
    assign clr = (own && (op_i == OP_COND)) ||
                 (wr_i && (addr_q[g] == addr_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        addr_q[g] <= '0;
      end else if (set) begin
        vld_q[g]  <= 1'b1;
        addr_q[g] <= addr_i;
      end else if (clr) begin
        vld_q[g]  <= 1'b0;
      end
    end
  end

  assign hit_o = vld_q[gnt_idx_i] && (addr_q[gnt_idx_i] == addr_i);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CORES-1:0]          req_valid_i,
  input  logic [2*N_CORES-1:0]        req_op_i,
  input  logic [N_CORES*ADDR_W-1:0]   req_addr_i,
  input  logic [N_CORES*DATA_W-1:0]   req_wdata_i,
  output logic [N_CORES-1:0]          grant_o,
  output logic [N_CORES-1:0]          rsp_valid_o,
  output logic [DATA_W-1:0]           rsp_data_o
);
  localparam int unsigned IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic [IDX_W-1:0]  gnt_idx;
  logic              gnt_any;
  mem_op_e           op_sel;
  logic [ADDR_W-1:0] addr_sel;
  logic [DATA_W-1:0] wdata_sel;
  logic [DATA_W-1:0] rdata;
  logic              resv_hit;
  logic              wr_en;
  logic [DATA_W-1:0] rsp_d;
  logic [N_CORES-1:0] rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;

  llsc_rr_arbiter #(.N(N_CORES)) arb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_valid_i),
    .gnt_o  (grant_o),
    .idx_o  (gnt_idx),
    .any_o  (gnt_any)
  );

  assign op_sel    = mem_op_e'(req_op_i[gnt_idx*2 +: 2]);
  assign addr_sel  = req_addr_i[gnt_idx*ADDR_W +: ADDR_W];
  assign wdata_sel = req_wdata_i[gnt_idx*DATA_W +: DATA_W];

  llsc_resv_table #(.N(N_CORES), .ADDR_W(ADDR_W)) resv_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gnt_any_i (gnt_any),
    .gnt_idx_i (gnt_idx),
    .op_i      (op_sel),
    .addr_i    (addr_sel),
    .wr_i      (wr_en),
    .hit_o     (resv_hit)
  );

  assign wr_en = gnt_any &&
                 ((op_sel == OP_STORE) || ((op_sel == OP_COND) && resv_hit));

  llsc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .addr_i  (addr_sel),
    .wdata_i (wdata_sel),
    .rdata_o (rdata)
  );

  always_comb begin
    unique case (op_sel)
      OP_LOAD, OP_LINK: rsp_d = rdata;
      OP_STORE:         rsp_d = '0;
      OP_COND:          rsp_d = DATA_W'(resv_hit);
      default:          rsp_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= grant_o;
      if (gnt_any) rsp_data_q <= rsp_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned DATA_W  = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_CORES-1:0]   req_valid_i,
  input logic [2*N_CORES-1:0] req_op_i,
  input logic [N_CORES-1:0]   grant_o,
  input logic [N_CORES-1:0]   rsp_valid_o,
  input logic [DATA_W-1:0]    rsp_data_o
);
  logic [N_CORES-1:0] is_cond, is_store;
  for (genvar c = 0; c < int'(N_CORES); c++) begin : g_op
    assign is_cond[c]  = (req_op_i[2*c +: 2] == 2'b11);
    assign is_store[c] = (req_op_i[2*c +: 2] == 2'b01);
  end

  logic sc_gnt, st_gnt;
  assign sc_gnt = |(grant_o & is_cond);
  assign st_gnt = |(grant_o & is_store);

  // R10
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R10
  grant_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_valid_i) == '0);

  // R10
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rsp_valid_o == $past(grant_o)));

  // R5
  sc_bool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_gnt |=> (rsp_data_o <= DATA_W'(1)));

  // R3
  st_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_gnt |=> (rsp_data_o == '0));
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .N_CORES(N_CORES),
  .DATA_W (DATA_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .grant_o     (grant_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o)
);

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]    b_valid;
  logic [1:0]      b_op   [N];
  logic [AW-1:0]   b_addr [N];
  logic [DW-1:0]   b_data [N];
  logic [2*N-1:0]  op_flat;
  logic [N*AW-1:0] addr_flat;
  logic [N*DW-1:0] data_flat;
  logic [N-1:0]    grant_o, rsp_valid_o;
  logic [DW-1:0]   rsp_data_o;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      op_flat[2*c +: 2]     = b_op[c];
      addr_flat[c*AW +: AW] = b_addr[c];
      data_flat[c*DW +: DW] = b_data[c];
    end
  end

  llsc_monitor #(.N_CORES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (b_valid),
    .req_op_i    (op_flat),
    .req_addr_i  (addr_flat),
    .req_wdata_i (data_flat),
    .grant_o     (grant_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench-side reference state derived from the requirements
  logic [DW-1:0] mem_m [DEPTH];
  logic          rv_m  [N];
  logic [AW-1:0] ra_m  [N];
  int            last_m = N - 1;
  int            sc_ones;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step_model(input int w, output logic [DW-1:0] exp);
    logic ok;
    case (b_op[w])
      2'b00: exp = mem_m[b_addr[w]];
      2'b01: begin
        mem_m[b_addr[w]] = b_data[w];
        for (int c = 0; c < N; c++) if (ra_m[c] == b_addr[w]) rv_m[c] = 1'b0;
        exp = '0;
      end
      2'b10: begin
        exp = mem_m[b_addr[w]];
        rv_m[w] = 1'b1;
        ra_m[w] = b_addr[w];
      end
      default: begin
        ok = rv_m[w] && (ra_m[w] == b_addr[w]);
        rv_m[w] = 1'b0;
        if (ok) begin
          mem_m[b_addr[w]] = b_data[w];
          for (int c = 0; c < N; c++) if (ra_m[c] == b_addr[w]) rv_m[c] = 1'b0;
        end
        exp = DW'(ok);
      end
    endcase
  endtask

  task automatic run_group(input logic [N-1:0] mask, input string tag, output logic [DW-1:0] last_rsp);
    logic [N-1:0]  pending;
    logic [DW-1:0] exp;
    logic          is_sc;
    int            w;
    @(negedge clk);
    b_valid = mask;
    pending = mask;
    last_rsp = '0;
    while (pending != '0) begin
      w = -1;
      for (int k = 1; k <= N; k++) begin
        int cand;
        cand = (last_m + k) % N;
        if (w < 0 && pending[cand]) w = cand;
      end
      #1;
      chk({tag, " R11 grant"}, 32'(grant_o), 32'(1 << w));
      @(posedge clk);
      #1;
      is_sc = (b_op[w] == 2'b11);
      step_model(w, exp);
      chk({tag, " R10 rsp_valid"}, 32'(rsp_valid_o), 32'(1 << w));
      chk({tag, " data"}, 32'(rsp_data_o), 32'(exp));
      if (is_sc && rsp_data_o == 1) sc_ones++;
      last_rsp = rsp_data_o;
      last_m = w;
      pending[w] = 1'b0;
      b_valid[w] = 1'b0;
    end
  endtask

  task automatic single(input int c, input logic [1:0] op, input int a, input logic [DW-1:0] d,
                        input string tag, output logic [DW-1:0] r);
    b_op[c]   = op;
    b_addr[c] = AW'(a);
    b_data[c] = d;
    run_group(N'(1 << c), tag, r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R10: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r, v;
    b_valid = '0;
    for (int c = 0; c < N; c++) begin
      b_op[c] = 2'b00; b_addr[c] = '0; b_data[c] = '0;
      rv_m[c] = 1'b0; ra_m[c] = '0;
    end
    for (int a = 0; a < DEPTH; a++) mem_m[a] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid_o), 0);
    chk("R1 grant in reset", 32'(grant_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 32'(rsp_valid_o), 0);

    // R1: memory clear
    for (int a = 0; a < DEPTH; a++) begin
      single(a % N, 2'b00, a, '0, "R1 load", r);
      chk("R1 zero word", 32'(r), 0);
    end
    // R1 / R6: no reservation after reset
    for (int c = 0; c < N; c++) begin
      single(c, 2'b11, 2, 16'hDEAD, "R6 sc no resv", r);
      chk("R1 sc fails after reset", 32'(r), 0);
    end
    single(0, 2'b00, 2, '0, "R6 load", r);
    chk("R6 memory untouched", 32'(r), 0);

    // R2 / R3 sweep
    for (int c = 0; c < N; c++)
      for (int a = 0; a < DEPTH; a++) begin
        v = DW'(16'h1000 * (c + 1) + a * 17);
        single(c, 2'b01, a, v, "R3 store", r);
        chk("R3 store resp", 32'(r), 0);
        single((c + 1) % N, 2'b00, a, '0, "R2 load", r);
        chk("R2 load value", 32'(r), 32'(v));
      end

    // R4 / R5 / R8 sweep
    for (int c = 0; c < N; c++)
      for (int a = 0; a < DEPTH; a++) begin
        v = mem_m[a];
        single(c, 2'b10, a, '0, "R4 link", r);
        chk("R4 link value", 32'(r), 32'(v));
        v = DW'(16'hA000 + c * 16 + a);
        single(c, 2'b11, a, v, "R5 sc", r);
        chk("R5 sc success", 32'(r), 1);
        single(c, 2'b00, a, '0, "R5 load", r);
        chk("R5 written", 32'(r), 32'(v));
        single(c, 2'b11, a, 16'hFFFF, "R8 sc again", r);
        chk("R8 second sc fails", 32'(r), 0);
        single(c, 2'b00, a, '0, "R8 load", r);
        chk("R8 memory kept", 32'(r), 32'(v));
      end

    // R7: interference between every ordered pair
    for (int c = 0; c < N; c++)
      for (int d = 0; d < N; d++) begin
        if (c == d) continue;
        v = DW'(16'h7000 + c * 4 + d);
        single(c, 2'b10, 3, '0, "R7 link", r);
        single(d, 2'b01, 3, v, "R7 store other", r);
        single(c, 2'b11, 3, 16'h0BAD, "R7 sc", r);
        chk("R7 sc after foreign store fails", 32'(r), 0);
        single(c, 2'b00, 3, '0, "R7 load", r);
        chk("R7 foreign value kept", 32'(r), 32'(v));
        single(c, 2'b10, 3, '0, "R7 link", r);
        single(d, 2'b01, 5, v, "R7 store elsewhere", r);
        single(c, 2'b11, 3, DW'(16'h5500 + c), "R7 sc", r);
        chk("R7 sc survives other address", 32'(r), 1);
        single(d, 2'b10, 3, '0, "R7 link d", r);
        single(c, 2'b10, 3, '0, "R7 link c", r);
        single(d, 2'b11, 3, DW'(16'h6600 + d), "R7 sc d", r);
        chk("R7 first sc wins", 32'(r), 1);
        single(c, 2'b11, 3, 16'h0BAD, "R7 sc c", r);
        chk("R7 sc after foreign sc fails", 32'(r), 0);
      end

    // R9: replacement
    single(1, 2'b10, 8, '0, "R9 link", r);
    single(1, 2'b10, 9, '0, "R9 link", r);
    single(1, 2'b11, 9, 16'h9999, "R9 sc", r);
    chk("R9 latest address succeeds", 32'(r), 1);
    single(1, 2'b10, 8, '0, "R9 link", r);
    single(1, 2'b10, 9, '0, "R9 link", r);
    single(1, 2'b11, 8, 16'h8888, "R9 sc", r);
    chk("R9 old address fails", 32'(r), 0);

    // R6: address mismatch
    v = mem_m[6];
    single(2, 2'b10, 4, '0, "R6 link", r);
    single(2, 2'b11, 6, 16'hEEEE, "R6 sc mismatch", r);
    chk("R6 mismatch fails", 32'(r), 0);
    single(2, 2'b00, 6, '0, "R6 load", r);
    chk("R6 memory unchanged", 32'(r), 32'(v));

    // R12: simultaneous conditional stores
    for (int c = 0; c < N; c++) single(c, 2'b10, 7, '0, "R12 link", r);
    v = DW'(16'hC000 + (last_m + 1) % N);
    for (int c = 0; c < N; c++) begin
      b_op[c] = 2'b11; b_addr[c] = 4'd7; b_data[c] = DW'(16'hC000 + c);
    end
    sc_ones = 0;
    run_group('1, "R12 race", r);
    chk("R12 single winner", 32'(sc_ones), 1);
    single(0, 2'b00, 7, '0, "R12 load", r);
    chk("R12 winner data", 32'(r), 32'(v));

    // R11: every request pattern, twice to rotate the pointer
    for (int rep = 0; rep < 2; rep++)
      for (int m = 1; m < (1 << N); m++) begin
        for (int c = 0; c < N; c++) begin
          b_op[c] = 2'b00; b_addr[c] = AW'(c + m);
        end
        run_group(N'(m), "R11 sweep", r);
      end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule